// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block collects the four interrupt sources of one UART channel and turns them into a single interrupt request plus a status code. The sources are a sticky line-error flag, the receive-data-ready or receive-timeout level, a transmit-holding-empty event, and a change on one of the four modem inputs. Each source is gated by its own bit of a four-bit enable word. The status code names only the most urgent pending source. Software reads the code, services that source, and reads again until the code says nothing is pending.

The block also keeps the four modem delta bits. It compares each modem input with the value it held on the previous clock. A diagnostic loop mode swaps the external modem inputs for internally driven copies, and interrupts keep working in that mode. Register decode, the FIFOs and the serial shift engines sit outside and reach this block only through level inputs and one-cycle strobes.

Top module: `uart_irq_prio`

## Requirements
- R1: With enable bit 0 set, a high `rx_ready_i` or `rx_tmo_i` is reported in the same cycle. The code is 4'b1100 when `rx_tmo_i` is high, otherwise 4'b0100, and `irq_o` goes high. The report drops when the level drops.
- R2: A `line_err_i` strobe latches a line-error pending flag. With enable bit 2 set, the code reads 4'b0110 from the next cycle on. The flag holds until an `lsr_rd_i` strobe clears it. A new error in the same cycle as that strobe keeps the flag set.
- R3: The transmit-empty pending flag is set when `thr_empty_i` rises. It is also set when enable bit 1 rises while `thr_empty_i` is high. With enable bit 1 set, the code reads 4'b0010.
- R4: The transmit-empty flag is cleared by a `thr_wr_i` strobe. It is also cleared by an `isr_rd_i` strobe in a cycle where the code shows 4'b0010. A clear wins over a set in the same cycle.
- R5: `delta_o` bit 0 (CTS), bit 1 (DSR) and bit 3 (CD) are set one cycle after their modem input changes in either direction. The reference value after reset is 0. With enable bit 3 set, any set delta bit gives code 4'b0000.
- R6: `delta_o` bit 2 (RI) is set only when the RI input goes from 1 to 0. A 0-to-1 change leaves it clear.
- R7: An `msr_rd_i` strobe clears all delta bits. A modem change sampled in the same cycle still sets its bit.
- R8: Priority runs from line error, to receive, to transmit-empty, to modem. Code bit 0 is 0 whenever an enabled source is pending. The code is 4'b0001 when none is pending.
- R9: A source whose enable bit is clear is not reported and does not raise `irq_o`. With all four enable bits clear, `irq_o` stays low and the code stays 4'b0001. Latched flags survive and are reported once enabled.
- R10: While `loopback_i` is high, deltas come from `loop_mdm_i`, and changes on `mdm_i` have no effect.
- R11: After reset, `irq_o` is 0, the code is 4'b0001 and `delta_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ier_i | input | 4 | Enables: bit 0 receive, bit 1 transmit-empty, bit 2 line error, bit 3 modem |
| rx_ready_i | input | 1 | Receive data available level |
| rx_tmo_i | input | 1 | Receive timeout level |
| line_err_i | input | 1 | Strobe: a line error was detected |
| lsr_rd_i | input | 1 | Strobe: line status read |
| thr_empty_i | input | 1 | Transmit holding register empty level |
| thr_wr_i | input | 1 | Strobe: transmit holding register written |
| isr_rd_i | input | 1 | Strobe: status code read |
| msr_rd_i | input | 1 | Strobe: modem status read |
| loopback_i | input | 1 | Select internal modem sources |
| mdm_i | input | 4 | External modem inputs: 0 CTS, 1 DSR, 2 RI, 3 CD (1 = asserted) |
| loop_mdm_i | input | 4 | Internal loop modem sources, same bit order |
| irq_o | output | 1 | Interrupt request, active high |
| code_o | output | 4 | Status code of the top pending source |
| delta_o | output | 4 | Modem delta bits, same bit order as `mdm_i` |

## Verification
The receive report and the enable gating (R1, R8, R9) are combinational and due in the same cycle the level or enable changes. Everything latched (line flag, transmit-empty flag, modem deltas and their clears) appears after the first rising edge that samples the strobe or change. The bench drives every input just after a falling edge and samples at the next falling edge. That single edge-to-edge step covers both the combinational and the one-register results. Strobes are held for exactly one such step.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    IC_MODEM = 4'b0000,
    IC_NONE  = 4'b0001,
    IC_THR   = 4'b0010,
    IC_RXDAT = 4'b0100,
    IC_LINE  = 4'b0110,
    IC_RXTMO = 4'b1100
  } irq_code_e;

  localparam int EN_RX    = 0;
  localparam int EN_THR   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_W     = 4;
  localparam int CODE_W   = 4;
endpackage

// File: rtl/uart_irq_rst_sync.sv
module uart_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sh_q <= '0;
    else              sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;

  always_comb begin
    if (SET_WINS) pend_d = set_i | (pend_q & ~clr_i);
    else          pend_d = ~clr_i & (set_i | pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  generate
    if (SET_WINS) begin : g_setwin
      // R2
      sticky_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_q);
    end else begin : g_clrwin
      // R4
      sticky_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !pend_q);
    end
  endgenerate

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(pend_q));
endmodule

// File: rtl/uart_irq_modem_delta.sv
module uart_irq_modem_delta #(
  parameter int               LINES      = 4,
  parameter logic [LINES-1:0] TRAIL_ONLY = 4'b0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] src_i,
  input  logic             clr_i,
  output logic [LINES-1:0] delta_o
);
  logic [LINES-1:0] prev_q, prev_d;
  logic [LINES-1:0] delta_q, delta_d;
  logic [LINES-1:0] evt;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      if (TRAIL_ONLY[i]) begin : g_trail
        assign evt[i] = prev_q[i] & ~src_i[i];
        // R6
        ri_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (!prev_q[i] && src_i[i] && !delta_q[i] && !clr_i) |=> !delta_q[i]);
      end else begin : g_any
        assign evt[i] = prev_q[i] ^ src_i[i];
      end
      // R5
      delta_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> delta_q[i]);
    end
  endgenerate

  always_comb begin
    prev_d  = src_i;
    delta_d = (clr_i ? '0 : delta_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= prev_d;
      delta_q <= delta_d;
    end
  end

  assign delta_o = delta_q;

  // R7
  delta_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt == '0) |=> (delta_q == '0));
endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic        line_p,
  input  logic        rx_p,
  input  logic        tmo_i,
  input  logic        thr_p,
  input  logic        mdm_p,
  output irq_code_e   code_o,
  output logic        any_o
);
  always_comb begin
    if (line_p)      code_o = IC_LINE;
    else if (rx_p)   code_o = tmo_i ? IC_RXTMO : IC_RXDAT;
    else if (thr_p)  code_o = IC_THR;
    else if (mdm_p)  code_o = IC_MODEM;
    else             code_o = IC_NONE;
    any_o = line_p | rx_p | thr_p | mdm_p;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int               MDM_W       = 4,
  parameter logic [MDM_W-1:0] MDM_TRAIL   = 4'b0100,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EN_W-1:0]  ier_i,
  input  logic             rx_ready_i,
  input  logic             rx_tmo_i,
  input  logic             line_err_i,
  input  logic             lsr_rd_i,
  input  logic             thr_empty_i,
  input  logic             thr_wr_i,
  input  logic             isr_rd_i,
  input  logic             msr_rd_i,
  input  logic             loopback_i,
  input  logic [MDM_W-1:0] mdm_i,
  input  logic [MDM_W-1:0] loop_mdm_i,
  output logic             irq_o,
  output logic [CODE_W-1:0] code_o,
  output logic [MDM_W-1:0] delta_o
);
  logic rst_n_s;
  logic thr_prev_q, thr_prev_d;
  logic ien_prev_q, ien_prev_d;
  logic thr_set, thr_clr, thr_q;
  logic line_q;
  logic [MDM_W-1:0] mdm_src;
  logic [MDM_W-1:0] delta;
  logic line_p, rx_p, thr_p, mdm_p, any;
  irq_code_e code;

  uart_irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_o(rst_n_s)
  );

  // modem source select for diagnostic loop
  always_comb mdm_src = loopback_i ? loop_mdm_i : mdm_i;

  // transmit-empty edge tracking
  always_comb begin
    thr_prev_d = thr_empty_i;
    ien_prev_d = ier_i[EN_THR];
    thr_set    = thr_empty_i & (~thr_prev_q | (ier_i[EN_THR] & ~ien_prev_q));
    thr_clr    = thr_wr_i | (isr_rd_i & (code == IC_THR));
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      thr_prev_q <= 1'b0;
      ien_prev_q <= 1'b0;
    end else begin
      thr_prev_q <= thr_prev_d;
      ien_prev_q <= ien_prev_d;
    end
  end

  uart_irq_sticky #(.SET_WINS(1'b1)) u_line (
    .clk(clk), .rst_n(rst_n_s), .set_i(line_err_i), .clr_i(lsr_rd_i), .pend_o(line_q)
  );

  uart_irq_sticky #(.SET_WINS(1'b0)) u_thr (
    .clk(clk), .rst_n(rst_n_s), .set_i(thr_set), .clr_i(thr_clr), .pend_o(thr_q)
  );

  uart_irq_modem_delta #(.LINES(MDM_W), .TRAIL_ONLY(MDM_TRAIL)) u_mdm (
    .clk(clk), .rst_n(rst_n_s), .src_i(mdm_src), .clr_i(msr_rd_i), .delta_o(delta)
  );

  // enable gating
  always_comb begin
    line_p = line_q & ier_i[EN_LINE];
    rx_p   = (rx_ready_i | rx_tmo_i) & ier_i[EN_RX];
    thr_p  = thr_q & ier_i[EN_THR];
    mdm_p  = (|delta) & ier_i[EN_MODEM];
  end

  uart_irq_prio_enc u_enc (
    .line_p(line_p), .rx_p(rx_p), .tmo_i(rx_tmo_i), .thr_p(thr_p),
    .mdm_p(mdm_p), .code_o(code), .any_o(any)
  );

  assign irq_o   = any;
  assign code_o  = code;
  assign delta_o = delta;

  // R9
  polled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ier_i == '0) |-> (!irq_o && code_o == IC_NONE));
  // R8
  line_top_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (line_q && ier_i[EN_LINE]) |-> (code_o == IC_LINE));
  // R8
  pend_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o |-> !code_o[0]);
  // R4
  thr_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (isr_rd_i && code_o == IC_THR) |=> !thr_q);
endmodule

// File: tb/uart_irq_prio_bench.sv
module uart_irq_prio_bench;
  logic       clk;
  logic       rst_n;
  logic [3:0] ier;
  logic       rx_ready, rx_tmo, line_err, lsr_rd, thr_empty, thr_wr, isr_rd, msr_rd, loopback;
  logic [3:0] mdm, loop_mdm;
  logic       irq;
  logic [3:0] code, delta;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  uart_irq_prio u_uart_irq_prio (
    .clk(clk), .rst_n(rst_n), .ier_i(ier), .rx_ready_i(rx_ready), .rx_tmo_i(rx_tmo),
    .line_err_i(line_err), .lsr_rd_i(lsr_rd), .thr_empty_i(thr_empty), .thr_wr_i(thr_wr),
    .isr_rd_i(isr_rd), .msr_rd_i(msr_rd), .loopback_i(loopback), .mdm_i(mdm),
    .loop_mdm_i(loop_mdm), .irq_o(irq), .code_o(code), .delta_o(delta)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {ier, rx_ready, rx_tmo, expected code, expected irq}
  localparam logic [10:0] VEC [8] = '{
    {4'b0001, 1'b1, 1'b0, 4'b0100, 1'b1},
    {4'b0001, 1'b0, 1'b1, 4'b1100, 1'b1},
    {4'b0001, 1'b1, 1'b1, 4'b1100, 1'b1},
    {4'b0001, 1'b0, 1'b0, 4'b0001, 1'b0},
    {4'b1100, 1'b1, 1'b1, 4'b0001, 1'b0},
    {4'b0000, 1'b1, 1'b0, 4'b0001, 1'b0},
    {4'b1101, 1'b1, 1'b0, 4'b0100, 1'b1},
    {4'b0001, 1'b1, 1'b0, 4'b0100, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    rst_n = 1'b0; ier = '0; rx_ready = 0; rx_tmo = 0; line_err = 0; lsr_rd = 0;
    thr_empty = 0; thr_wr = 0; isr_rd = 0; msr_rd = 0; loopback = 0; mdm = '0; loop_mdm = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R11 reset state
    chk("R11 irq", irq, 0);
    chk("R11 code", code, 4'b0001);
    chk("R11 delta", delta, 0);

    // R1 / R9 table
    for (int i = 0; i < 8; i++) begin
      {ier, rx_ready, rx_tmo} = VEC[i][10:5];
      tick();
      chk("R1/R9 vec code", code, VEC[i][4:1]);
      chk("R1/R9 vec irq", irq, VEC[i][0]);
    end

    // R2 / R8 line error over receive
    ier = 4'b1111; rx_ready = 1; line_err = 1; tick(); line_err = 0;
    chk("R2 R8 line top", code, 4'b0110);
    tick();
    chk("R2 line held", code, 4'b0110);
    lsr_rd = 1; tick(); lsr_rd = 0;
    chk("R2 line cleared", code, 4'b0100);
    rx_ready = 0; tick();
    chk("R1 rx drop", code, 4'b0001);

    // R3 / R4 transmit empty
    thr_empty = 1; tick();
    chk("R3 thr rise", code, 4'b0010);
    chk("R3 irq", irq, 1);
    isr_rd = 1; tick(); isr_rd = 0;
    chk("R4 read clear", code, 4'b0001);
    thr_empty = 0; tick(); thr_empty = 1; tick();
    chk("R3 thr rise again", code, 4'b0010);
    thr_wr = 1; tick(); thr_wr = 0;
    chk("R4 write clear", code, 4'b0001);
    ier = 4'b1101; tick(); ier = 4'b1111; tick();
    chk("R3 enable rise", code, 4'b0010);
    thr_wr = 1; thr_empty = 0; tick(); thr_wr = 0;
    chk("R4 write clear2", code, 4'b0001);

    // R5 / R8 modem
    mdm[0] = 1; tick();
    chk("R5 cts delta", delta, 4'b0001);
    chk("R5 modem code", code, 4'b0000);
    thr_empty = 1; tick();
    chk("R8 thr over modem", code, 4'b0010);
    thr_wr = 1; tick(); thr_wr = 0;
    chk("R8 modem after thr", code, 4'b0000);
    msr_rd = 1; tick(); msr_rd = 0;
    chk("R7 read clear", delta, 0);
    chk("R7 code none", code, 4'b0001);
    mdm[2] = 1; tick();
    chk("R6 ri rise quiet", delta, 0);
    mdm[2] = 0; tick();
    chk("R6 ri fall", delta, 4'b0100);
    msr_rd = 1; mdm[1] = 1; tick(); msr_rd = 0;
    chk("R7 change wins", delta, 4'b0010);
    msr_rd = 1; tick(); msr_rd = 0;
    chk("R7 clear again", delta, 0);

    // R10 loopback
    loop_mdm = mdm; loopback = 1; tick();
    chk("R10 switch quiet", delta, 0);
    mdm[1] = 0; tick();
    chk("R10 external ignored", delta, 0);
    loop_mdm[3] = 1; tick();
    chk("R10 loop cd", delta, 4'b1000);
    msr_rd = 1; mdm = loop_mdm; tick(); msr_rd = 0; loopback = 0; tick();
    chk("R10 back quiet", delta, 0);

    // R9 polled
    ier = 4'b0000; line_err = 1; rx_ready = 1; tick(); line_err = 0;
    chk("R9 polled irq", irq, 0);
    chk("R9 polled code", code, 4'b0001);
    ier = 4'b0100; tick();
    chk("R9 latched kept", code, 4'b0110);

    // R2 set wins over read
    lsr_rd = 1; line_err = 1; tick(); lsr_rd = 0; line_err = 0;
    chk("R2 set wins", code, 4'b0110);
    lsr_rd = 1; tick(); lsr_rd = 0; rx_ready = 0;
    chk("R2 final clear", code, 4'b0001);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule